// File: doc/BRIEF.md
# Short-Circuit Retry Timing Controller

This block supervises a group of high-side switch channels. Each channel has its own on/off command and its own overcurrent flag from the analog current limiter. If a commanded-on channel reports an overcurrent, it keeps conducting in current-limited mode for a programmed ON window. If the overcurrent is still there when that window ends, the channel is forced off for a programmed OFF window. After the OFF window the channel either retries with another ON window or, if the fault has gone, returns to plain conduction. This keeps a shorted load from heating the whole die, while loads with large inrush currents, such as capacitive loads or cold lamp filaments, can still start.

The ON and OFF settings are shared by all channels and given in timer units. Each unit lasts `PRESCALE` clock cycles. Each setting has an "unset" strobe that stands in for a setting that has not been programmed:
- If only the OFF setting is unset, the OFF window becomes 64 times the ON window.
- If only the ON setting is unset, the ON window has zero length.
- If both settings are unset, the retry scheme is switched off completely.

The channel fault flag is raised only while the channel is held off by the scheme.

Top module: `sc_retry_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every channel returns to idle. After that edge `sw_en`, `lim_act` and `ch_fault` are all 0.
- R2: A channel whose `ch_cmd` bit rises with no overcurrent drives its `sw_en` bit to 1 after the next clock edge. An overcurrent flag on a channel that is not commanded on has no effect on that channel's outputs.
- R3: An overcurrent seen at a clock edge while a channel is conducting normally puts it in limited conduction (`lim_act`=1, `sw_en`=1) from the next cycle. It stays there for exactly `on_period`×`PRESCALE` cycles.
- R4: If the overcurrent is present at the last cycle of the ON window, the channel is forced off (`sw_en`=0) for the OFF window. At the last cycle of the OFF window, an overcurrent that is still present starts a new ON window; otherwise the channel returns to normal conduction.
- R5: `ch_fault` is 1 exactly while the channel is forced off. It stays 0 during the ON window, even though the overcurrent is present then.
- R6: With `off_unset`=1 and `on_unset`=0, the OFF window lasts `on_period`×64×`PRESCALE` cycles.
- R7: With both `on_unset` and `off_unset` at 1, a commanded-on channel keeps `sw_en`=1, `lim_act`=0 and `ch_fault`=0 whatever its overcurrent flag does.
- R8: A channel whose `ch_cmd` bit is 0 at a clock edge is idle after that edge, with all three outputs at 0. This holds whatever part of the retry cycle the channel was in.
- R9: With `on_unset`=1 and `off_unset`=0, the ON window has zero length. An overcurrent sends the channel straight from normal conduction, or from the end of an OFF window, into a new OFF window.
- R10: An OFF window that works out to zero cycles lasts one cycle instead.
- R11: Channels are independent. A fault cycle on one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_cmd | input | NUM_CH | Per-channel on command |
| ch_ovc | input | NUM_CH | Per-channel overcurrent flag from the limiter |
| on_period | input | CNT_W | ON window length in timer units |
| off_period | input | CNT_W | OFF window length in timer units |
| on_unset | input | 1 | ON setting not programmed |
| off_unset | input | 1 | OFF setting not programmed |
| sw_en | output | NUM_CH | Switch enable per channel |
| lim_act | output | NUM_CH | Channel is in its current-limited ON window |
| ch_fault | output | NUM_CH | Channel is forced off by the retry cycle |

## Verification
The bench checks the exact length of each window, one cycle at a time. A timer that is off by one would make the limited or forced-off phase one cycle too long or too short. The bench also covers two cases that are easy to get wrong: a retry decision taken with the overcurrent still present at the end of the OFF window, and the default OFF window of 64 ON windows. A design that sampled the flag at the wrong cycle would resume too early in the first case, and an unscaled default would cut the OFF window short in the second. The zero-length ON window, the one-cycle OFF floor, the inhibited mode and an abort by the command are each driven on a channel while a neighbouring channel stays on. This exposes a fault flag raised during the ON window, a design that fails to stay inhibited, or state that leaks between channels.

// File: rtl/sc_retry_pkg.sv
package sc_retry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_ON_NORMAL  = 2'd1,
    ST_ON_LIMIT   = 2'd2,
    ST_FORCED_OFF = 2'd3
  } sc_state_e;

  // OFF window defaults to the ON window times 2**OFF_DEFAULT_SHIFT
  localparam int unsigned OFF_DEFAULT_SHIFT = 6;
endpackage

// File: rtl/sc_window_calc.sv
module sc_window_calc
  import sc_retry_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned WIN_W    = 17
) (
  input  logic [CNT_W-1:0] on_period,
  input  logic [CNT_W-1:0] off_period,
  input  logic             on_unset,
  input  logic             off_unset,
  output logic [WIN_W-1:0] on_win,
  output logic [WIN_W-1:0] off_win,
  output logic             on_zero,
  output logic             inhibit
);
  localparam int unsigned UNIT_W = CNT_W + OFF_DEFAULT_SHIFT;

  // timer units to clock cycles
  function automatic logic [WIN_W-1:0] units_to_cycles(input logic [UNIT_W-1:0] units);
    return WIN_W'(units) * WIN_W'(PRESCALE);
  endfunction

  // unset OFF setting: scaled copy of the ON setting
  function automatic logic [UNIT_W-1:0] off_units_sel(input logic [CNT_W-1:0] on_p,
                                                      input logic [CNT_W-1:0] off_p,
                                                      input logic             off_u);
    return off_u ? (UNIT_W'(on_p) << OFF_DEFAULT_SHIFT) : UNIT_W'(off_p);
  endfunction

  logic [UNIT_W-1:0] on_units;
  logic [WIN_W-1:0]  off_raw;

  assign on_units = on_unset ? '0 : UNIT_W'(on_period);
  assign on_win   = units_to_cycles(on_units);
  assign off_raw  = units_to_cycles(off_units_sel(on_period, off_period, off_unset));
  assign off_win  = (off_raw == '0) ? WIN_W'(1) : off_raw;  // R10 floor
  assign on_zero  = (on_win == '0);
  assign inhibit  = on_unset && off_unset;
endmodule

// File: rtl/sc_window_timer.sv
module sc_window_timer #(
  parameter int unsigned WIN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [WIN_W-1:0] len,
  output logic             win_last
);
  logic [WIN_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || restart) elapsed <= '0;
    else if (elapsed != '1) elapsed <= elapsed + WIN_W'(1);
  end

  // current cycle is the last one of a window of length len
  assign win_last = ((WIN_W+1)'(elapsed) + (WIN_W+1)'(1)) >= {1'b0, len};

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (elapsed == '0));
endmodule

// File: rtl/sc_chan_fsm.sv
module sc_chan_fsm
  import sc_retry_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd,
  input  logic      ovc,
  input  logic      inhibit,
  input  logic      on_zero,
  input  logic      win_last,
  output sc_state_e state,
  output logic      restart,
  output logic      en,
  output logic      lim,
  output logic      fault
);
  sc_state_e nxt;
  sc_state_e limit_entry;

  // zero ON window skips straight to the OFF window
  assign limit_entry = on_zero ? ST_FORCED_OFF : ST_ON_LIMIT;

  always_comb begin
    nxt = state;
    if (!cmd)         nxt = ST_IDLE;
    else if (inhibit) nxt = ST_ON_NORMAL;
    else begin
      unique case (state)
        ST_IDLE:       nxt = ST_ON_NORMAL;
        ST_ON_NORMAL:  if (ovc) nxt = limit_entry;
        ST_ON_LIMIT:   if (win_last) nxt = ovc ? ST_FORCED_OFF : ST_ON_NORMAL;
        ST_FORCED_OFF: if (win_last) nxt = ovc ? limit_entry : ST_ON_NORMAL;
        default:       nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign restart = (nxt != state) || (state == ST_FORCED_OFF && win_last);
  assign en      = (state == ST_ON_NORMAL) || (state == ST_ON_LIMIT);
  assign lim     = (state == ST_ON_LIMIT);
  assign fault   = (state == ST_FORCED_OFF);

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd |=> (state == ST_IDLE));
  p_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd && inhibit) |=> (state == ST_ON_NORMAL));
  p_limit_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON_NORMAL && cmd && ovc && !inhibit && !on_zero) |=> (state == ST_ON_LIMIT));
  p_retry_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FORCED_OFF && win_last && cmd && ovc && !inhibit && !on_zero)
      |=> (state == ST_ON_LIMIT));
  p_skip_on_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON_NORMAL && cmd && ovc && !inhibit && on_zero) |=> (state == ST_FORCED_OFF));
  p_limit_not_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON_LIMIT && !win_last && cmd && !inhibit) |=> !fault);
endmodule

// File: rtl/sc_retry_ctrl.sv
module sc_retry_ctrl
  import sc_retry_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_cmd,
  input  logic [NUM_CH-1:0] ch_ovc,
  input  logic [CNT_W-1:0]  on_period,
  input  logic [CNT_W-1:0]  off_period,
  input  logic              on_unset,
  input  logic              off_unset,
  output logic [NUM_CH-1:0] sw_en,
  output logic [NUM_CH-1:0] lim_act,
  output logic [NUM_CH-1:0] ch_fault
);
  localparam int unsigned WIN_W = CNT_W + OFF_DEFAULT_SHIFT + $clog2(PRESCALE + 1);

  logic [WIN_W-1:0] on_win;
  logic [WIN_W-1:0] off_win;
  logic             on_zero;
  logic             inhibit;

  sc_window_calc #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .WIN_W(WIN_W)) u_calc (
    .on_period (on_period),
    .off_period(off_period),
    .on_unset  (on_unset),
    .off_unset (off_unset),
    .on_win    (on_win),
    .off_win   (off_win),
    .on_zero   (on_zero),
    .inhibit   (inhibit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sc_state_e        state;
    logic             restart;
    logic             win_last;
    logic [WIN_W-1:0] len;

    assign len = (state == ST_FORCED_OFF) ? off_win : on_win;

    sc_window_timer #(.WIN_W(WIN_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .len     (len),
      .win_last(win_last)
    );

    sc_chan_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .cmd     (ch_cmd[c]),
      .ovc     (ch_ovc[c]),
      .inhibit (inhibit),
      .on_zero (on_zero),
      .win_last(win_last),
      .state   (state),
      .restart (restart),
      .en      (sw_en[c]),
      .lim     (lim_act[c]),
      .fault   (ch_fault[c])
    );

    p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (state == ST_IDLE));
  end
endmodule

// File: tb/sc_retry_ctrl_test.sv
module sc_retry_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cmd = '0, ovc = '0;
  logic [7:0] onp = 8'd3, offp = 8'd5;
  logic onu = 1'b0, offu = 1'b0;
  logic [NCH-1:0] en, lim, flt;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_retry_ctrl #(.NUM_CH(NCH), .CNT_W(8), .PRESCALE(PRE)) uut (
    .clk(clk), .rst(rst), .ch_cmd(cmd), .ch_ovc(ovc),
    .on_period(onp), .off_period(offp), .on_unset(onu), .off_unset(offu),
    .sw_en(en), .lim_act(lim), .ch_fault(flt));

  // reference model: 0 idle, 1 normal, 2 limited, 3 forced off
  int md[NCH];
  int rem[NCH];

  function automatic int on_len();
    return onu ? 0 : int'(onp) * PRE;
  endfunction
  function automatic int off_len();
    int v;
    v = offu ? int'(onp) * 64 * PRE : int'(offp) * PRE;
    return (v < 1) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst || !cmd[c]) md[c] = 0;
      else if (onu && offu) md[c] = 1;
      else if (md[c] == 0) md[c] = 1;
      else if (md[c] == 1) begin
        if (ovc[c]) begin
          if (on_len() == 0) begin md[c] = 3; rem[c] = off_len(); end
          else begin md[c] = 2; rem[c] = on_len(); end
        end
      end else if (md[c] == 2) begin
        rem[c] = rem[c] - 1;
        if (rem[c] <= 0) begin
          if (ovc[c]) begin md[c] = 3; rem[c] = off_len(); end
          else md[c] = 1;
        end
      end else begin
        rem[c] = rem[c] - 1;
        if (rem[c] <= 0) begin
          if (!ovc[c]) md[c] = 1;
          else if (on_len() == 0) begin md[c] = 3; rem[c] = off_len(); end
          else begin md[c] = 2; rem[c] = on_len(); end
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++) begin
        check("R2", $sformatf("model sw_en[%0d]", c), int'(en[c]), int'(md[c] == 1 || md[c] == 2));
        check("R3", $sformatf("model lim_act[%0d]", c), int'(lim[c]), int'(md[c] == 2));
        check("R5", $sformatf("model ch_fault[%0d]", c), int'(flt[c]), int'(md[c] == 3));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    step(3);
    check("R1", "reset sw_en", int'(en), 0);
    check("R1", "reset lim_act", int'(lim), 0);
    check("R1", "reset ch_fault", int'(flt), 0);
    rst = 1'b0;

    // R2: overcurrent on an uncommanded channel is ignored
    ovc[1] = 1'b1;
    step(3);
    check("R2", "idle ovc sw_en[1]", int'(en[1]), 0);
    check("R2", "idle ovc ch_fault[1]", int'(flt[1]), 0);
    ovc[1] = 1'b0;

    // Scenario A: ON 12 cycles, OFF 20 cycles on channel 0; channel 3 stays on
    cmd[0] = 1'b1; cmd[3] = 1'b1;
    step(1);
    check("R2", "cmd on sw_en[0]", int'(en[0]), 1);
    ovc[0] = 1'b1;
    step(1);
    check("R3", "limit entry lim_act[0]", int'(lim[0]), 1);
    check("R5", "no fault in ON window", int'(flt[0]), 0);
    step(11);
    check("R3", "last ON cycle lim_act[0]", int'(lim[0]), 1);
    step(1);
    check("R4", "forced off sw_en[0]", int'(en[0]), 0);
    check("R5", "forced off ch_fault[0]", int'(flt[0]), 1);
    check("R11", "neighbour sw_en[3]", int'(en[3]), 1);
    check("R11", "neighbour ch_fault[3]", int'(flt[3]), 0);
    step(19);
    check("R4", "last OFF cycle ch_fault[0]", int'(flt[0]), 1);
    step(1);
    check("R4", "retry lim_act[0]", int'(lim[0]), 1);
    ovc[0] = 1'b0;
    step(11);
    check("R4", "retry window lim_act[0]", int'(lim[0]), 1);
    step(1);
    check("R4", "resume sw_en[0]", int'(en[0]), 1);
    check("R4", "resume lim_act[0]", int'(lim[0]), 0);

    // Scenario B: default OFF = 64 x ON (ON 4 cycles, OFF 256)
    onp = 8'd1; offu = 1'b1;
    cmd[1] = 1'b1;
    step(1);
    ovc[1] = 1'b1;
    step(1);
    check("R3", "B lim_act[1]", int'(lim[1]), 1);
    step(4);
    check("R6", "B forced off ch_fault[1]", int'(flt[1]), 1);
    step(255);
    check("R6", "B last OFF cycle ch_fault[1]", int'(flt[1]), 1);
    ovc[1] = 1'b0;
    step(1);
    check("R6", "B resume sw_en[1]", int'(en[1]), 1);
    check("R6", "B resume ch_fault[1]", int'(flt[1]), 0);
    cmd[1] = 1'b0;

    // Scenario D: abort by command during forced off
    onp = 8'd3; offu = 1'b0; offp = 8'd5;
    ovc[0] = 1'b1;
    step(13);
    check("R4", "D forced off ch_fault[0]", int'(flt[0]), 1);
    cmd[0] = 1'b0;
    step(1);
    check("R8", "abort ch_fault[0]", int'(flt[0]), 0);
    check("R8", "abort sw_en[0]", int'(en[0]), 0);
    cmd[0] = 1'b1;
    step(1);
    check("R8", "restart normal sw_en[0]", int'(en[0]), 1);
    check("R8", "restart normal lim_act[0]", int'(lim[0]), 0);
    step(1);
    check("R3", "restart limit lim_act[0]", int'(lim[0]), 1);
    cmd[0] = 1'b0;
    step(1);
    ovc[0] = 1'b0;

    // Scenario E: ON unset only, OFF 8 cycles
    onu = 1'b1; offp = 8'd2;
    cmd[2] = 1'b1;
    step(1);
    ovc[2] = 1'b1;
    step(1);
    check("R9", "E skip ON ch_fault[2]", int'(flt[2]), 1);
    check("R9", "E skip ON lim_act[2]", int'(lim[2]), 0);
    step(8);
    check("R9", "E re-enter OFF ch_fault[2]", int'(flt[2]), 1);
    ovc[2] = 1'b0;
    step(8);
    check("R9", "E resume sw_en[2]", int'(en[2]), 1);

    // Scenario F: OFF period zero -> one cycle
    onu = 1'b0; onp = 8'd1; offp = 8'd0;
    ovc[2] = 1'b1;
    step(5);
    check("R10", "F forced off ch_fault[2]", int'(flt[2]), 1);
    step(1);
    check("R10", "F one-cycle OFF lim_act[2]", int'(lim[2]), 1);
    ovc[2] = 1'b0;
    step(4);
    check("R10", "F resume sw_en[2]", int'(en[2]), 1);

    // Scenario C: both unset -> inhibited
    onu = 1'b1; offu = 1'b1;
    ovc[2] = 1'b1;
    step(50);
    check("R7", "inhibit sw_en[2]", int'(en[2]), 1);
    check("R7", "inhibit ch_fault[2]", int'(flt[2]), 0);
    check("R7", "inhibit lim_act[2]", int'(lim[2]), 0);

    cmd = '0; ovc = '0;
    step(2);
    check("R8", "all off sw_en", int'(en), 0);
    finish_run();
  end
endmodule